// File: doc/BRIEF.md
# Channel-Ordered Kernel Weight and Bias Loader

This block fills the coefficient storage of a convolution layer before the layer starts to compute. After a start strobe it takes one group of three weights per clock. Each group is one kernel row of one channel. Within a pass the channels arrive from the highest index down to the lowest. Three such passes fill rows 0, 1 and 2 of a four-channel, three-by-three kernel array. Each group is first held in a one-group in-flight stage. The array copies it from that stage on the following clock, so no separate drain step follows the last group.

Once the twelve weight cycles are over, one bias value per channel arrives on a single serial input. Each value is written straight into its bias register, again from the highest channel index down, over four cycles. The block then raises a one-cycle done flag and goes back to idle until the next start strobe. The whole array and all bias registers stay visible on flat output buses for the compute datapath.

Top module: `kwl_loader`

## Requirements
- R1: While `rst_ni` is low, and once it has been asserted, every weight and bias output bit and `done_o` read 0. Asserting it during a load abandons that load.
- R2: A high `start_i` sampled while the block is idle begins a load. `grp_i` is then sampled on each of the next 12 rising edges.
- R3: Group g (0..11) of a load belongs to kernel row g/4 and channel index 3-(g mod 4), so channel index 3 comes first in every pass. Lane k of `grp_i` (bits 8k+7..8k) is column k. Column k of row r, channel c appears on `weights_o` bits [((r*4+c)*3+k)*8 +: 8]. All values are 8-bit two's complement and are stored unchanged.
- R4: A weight group appears on `weights_o` one edge after the edge that samples it. The last group of a load is therefore written on the same edge as the first bias value.
- R5: `bias_i` is sampled on the 4 edges that follow the last weight edge, for channel indices 3, 2, 1, 0 in that order. Each value appears on `bias_o[c*8 +: 8]` right after its sampling edge. `bias_o` changes at no other time.
- R6: `done_o` is high for exactly one cycle, starting right after the 17th edge counted from the edge that accepted the start strobe (that edge being the 1st). It then returns low.
- R7: `start_i` has no effect during a load or while `done_o` is high.
- R8: While idle, `grp_i` and `bias_i` have no effect on any output. During the weight cycles `bias_i` is ignored, and during the bias cycles `grp_i` is ignored.
- R9: A start strobe on the first idle cycle after `done_o` begins a new load. That load overwrites every weight and bias entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Start strobe, accepted only when idle |
| grp_i | input | 24 | Three weights of one channel row, lane k in bits 8k+7..8k |
| bias_i | input | 8 | Serial bias value, one channel per cycle |
| weights_o | output | 288 | Kernel array, row-major over row, channel, column |
| bias_o | output | 32 | Bias registers, channel c in bits 8c+7..8c |
| done_o | output | 1 | One-cycle pulse when the load is complete |

## Verification
The last weight group leaves the in-flight stage on the same edge as the first bias value, which goes into channel index 3. The two writes go to different stores through different enables. A wrong enable or a wrong row or channel selection would therefore corrupt one of them. Every load drives distinct values and compares the whole weight bus and the whole bias bus after each edge. On the shared edge this shows that the pending row-2, channel-0 group has landed and that only bias channel 3 has changed, while the rest still holds its earlier value.

// File: rtl/kwl_pkg.sv
package kwl_pkg;

  // Load sequencer phases
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WLOAD = 2'd1,
    ST_BLOAD = 2'd2,
    ST_DONE  = 2'd3
  } kwl_state_e;

endpackage

// File: rtl/kwl_rst_sync.sv
module kwl_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_sync_no
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_sync_no = sync_q;

endmodule

// File: rtl/kwl_seq.sv
module kwl_seq
  import kwl_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int NUM_PASS = 3,
  parameter int CH_W     = 2,
  parameter int PASS_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [PASS_W-1:0] pass_o,
  output logic [CH_W-1:0]   ch_o,
  output logic              wcap_o,
  output logic              bload_o,
  output logic              done_o,
  output logic              start_acc_o
);

  localparam logic [CH_W-1:0]   TOP_CH    = CH_W'(NUM_CH - 1);
  localparam logic [PASS_W-1:0] LAST_PASS = PASS_W'(NUM_PASS - 1);

  kwl_state_e        state_q, state_d;
  logic [PASS_W-1:0] pass_q, pass_d;
  logic [CH_W-1:0]   ch_q, ch_d;
  logic              cnt_en;
  logic              start_acc;

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    pass_d    = pass_q;
    ch_d      = ch_q;
    cnt_en    = 1'b0;
    start_acc = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          start_acc = 1'b1;
          state_d   = ST_WLOAD;
          pass_d    = '0;
          ch_d      = TOP_CH;
          cnt_en    = 1'b1;
        end
      end
      ST_WLOAD: begin
        cnt_en = 1'b1;
        if (ch_q == '0) begin
          ch_d = TOP_CH;
          if (pass_q == LAST_PASS) begin
            state_d = ST_BLOAD;
          end else begin
            pass_d = pass_q + 1'b1;
          end
        end else begin
          ch_d = ch_q - 1'b1;
        end
      end
      ST_BLOAD: begin
        cnt_en = 1'b1;
        if (ch_q == '0) begin
          state_d = ST_DONE;
        end else begin
          ch_d = ch_q - 1'b1;
        end
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pass_q  <= '0;
      ch_q    <= '0;
    end else begin
      state_q <= state_d;
      if (cnt_en) begin
        pass_q <= pass_d;
        ch_q   <= ch_d;
      end
    end
  end

  assign pass_o      = pass_q;
  assign ch_o        = ch_q;
  assign wcap_o      = (state_q == ST_WLOAD);
  assign bload_o     = (state_q == ST_BLOAD);
  assign done_o      = (state_q == ST_DONE);
  assign start_acc_o = start_acc;

endmodule

// File: rtl/kwl_wstage.sv
module kwl_wstage #(
  parameter int DATA_W  = 8,
  parameter int ROW_LEN = 3,
  parameter int CH_W    = 2,
  parameter int PASS_W  = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cap_i,
  input  logic [ROW_LEN*DATA_W-1:0] grp_i,
  input  logic [PASS_W-1:0]         row_i,
  input  logic [CH_W-1:0]           ch_i,
  output logic [ROW_LEN*DATA_W-1:0] grp_o,
  output logic                      vld_o,
  output logic [PASS_W-1:0]         row_o,
  output logic [CH_W-1:0]           ch_o
);

  logic              vld_q;
  logic [PASS_W-1:0] row_q;
  logic [CH_W-1:0]   ch_q;

  // One in-flight register per weight lane
  for (genvar k = 0; k < ROW_LEN; k++) begin : g_lane
    logic [DATA_W-1:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lane_q <= '0;
      end else if (cap_i) begin
        lane_q <= grp_i[k*DATA_W +: DATA_W];
      end
    end
    assign grp_o[k*DATA_W +: DATA_W] = lane_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      row_q <= '0;
      ch_q  <= '0;
    end else begin
      vld_q <= cap_i;
      if (cap_i) begin
        row_q <= row_i;
        ch_q  <= ch_i;
      end
    end
  end

  assign vld_o = vld_q;
  assign row_o = row_q;
  assign ch_o  = ch_q;

endmodule

// File: rtl/kwl_store.sv
module kwl_store #(
  parameter int DATA_W   = 8,
  parameter int ROW_LEN  = 3,
  parameter int NUM_CH   = 4,
  parameter int NUM_PASS = 3,
  parameter int CH_W     = 2,
  parameter int PASS_W   = 2
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     wr_en_i,
  input  logic [PASS_W-1:0]                        wr_row_i,
  input  logic [CH_W-1:0]                          wr_ch_i,
  input  logic [ROW_LEN*DATA_W-1:0]                wr_grp_i,
  input  logic                                     b_en_i,
  input  logic [CH_W-1:0]                          b_ch_i,
  input  logic [DATA_W-1:0]                        b_val_i,
  output logic [NUM_PASS*NUM_CH*ROW_LEN*DATA_W-1:0] weights_o,
  output logic [NUM_CH*DATA_W-1:0]                  bias_o
);

  localparam int GRP_W = ROW_LEN * DATA_W;

  // Kernel slots: one group register per (row, channel)
  for (genvar r = 0; r < NUM_PASS; r++) begin : g_row
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic [GRP_W-1:0] slot_q;
      logic             slot_en;
      assign slot_en = wr_en_i && (wr_row_i == PASS_W'(r)) && (wr_ch_i == CH_W'(c));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          slot_q <= '0;
        end else if (slot_en) begin
          slot_q <= wr_grp_i;
        end
      end
      assign weights_o[(r*NUM_CH + c)*GRP_W +: GRP_W] = slot_q;
    end
  end

  // Bias registers written straight from the serial input
  for (genvar c = 0; c < NUM_CH; c++) begin : g_bias
    logic [DATA_W-1:0] b_q;
    logic              b_wen;
    assign b_wen = b_en_i && (b_ch_i == CH_W'(c));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        b_q <= '0;
      end else if (b_wen) begin
        b_q <= b_val_i;
      end
    end
    assign bias_o[c*DATA_W +: DATA_W] = b_q;
  end

endmodule

// File: rtl/kwl_loader.sv
module kwl_loader
  import kwl_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_CH   = 4,
  parameter int ROW_LEN  = 3,
  parameter int NUM_PASS = 3
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     start_i,
  input  logic [ROW_LEN*DATA_W-1:0]                grp_i,
  input  logic [DATA_W-1:0]                        bias_i,
  output logic [NUM_PASS*NUM_CH*ROW_LEN*DATA_W-1:0] weights_o,
  output logic [NUM_CH*DATA_W-1:0]                  bias_o,
  output logic                                     done_o
);

  localparam int CH_W   = (NUM_CH   > 1) ? $clog2(NUM_CH)   : 1;
  localparam int PASS_W = (NUM_PASS > 1) ? $clog2(NUM_PASS) : 1;
  localparam int GRP_W  = ROW_LEN * DATA_W;

  logic              rst_sync_n;
  logic [PASS_W-1:0] pass_cnt;
  logic [CH_W-1:0]   ch_cnt;
  logic              wcap;
  logic              bload;
  logic              start_acc;
  logic [GRP_W-1:0]  stg_grp;
  logic              stg_vld;
  logic [PASS_W-1:0] stg_row;
  logic [CH_W-1:0]   stg_ch;

  kwl_rst_sync u_rst (
    .clk_i      (clk_i),
    .arst_ni    (rst_ni),
    .rst_sync_no(rst_sync_n)
  );

  kwl_seq #(
    .NUM_CH  (NUM_CH),
    .NUM_PASS(NUM_PASS),
    .CH_W    (CH_W),
    .PASS_W  (PASS_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .start_i    (start_i),
    .pass_o     (pass_cnt),
    .ch_o       (ch_cnt),
    .wcap_o     (wcap),
    .bload_o    (bload),
    .done_o     (done_o),
    .start_acc_o(start_acc)
  );

  kwl_wstage #(
    .DATA_W (DATA_W),
    .ROW_LEN(ROW_LEN),
    .CH_W   (CH_W),
    .PASS_W (PASS_W)
  ) u_stage (
    .clk_i (clk_i),
    .rst_ni(rst_sync_n),
    .cap_i (wcap),
    .grp_i (grp_i),
    .row_i (pass_cnt),
    .ch_i  (ch_cnt),
    .grp_o (stg_grp),
    .vld_o (stg_vld),
    .row_o (stg_row),
    .ch_o  (stg_ch)
  );

  kwl_store #(
    .DATA_W  (DATA_W),
    .ROW_LEN (ROW_LEN),
    .NUM_CH  (NUM_CH),
    .NUM_PASS(NUM_PASS),
    .CH_W    (CH_W),
    .PASS_W  (PASS_W)
  ) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .wr_en_i  (stg_vld),
    .wr_row_i (stg_row),
    .wr_ch_i  (stg_ch),
    .wr_grp_i (stg_grp),
    .b_en_i   (bload),
    .b_ch_i   (ch_cnt),
    .b_val_i  (bias_i),
    .weights_o(weights_o),
    .bias_o   (bias_o)
  );

endmodule

// File: rtl/kwl_loader_chk.sv
module kwl_loader_chk #(
  parameter int DATA_W   = 8,
  parameter int NUM_CH   = 4,
  parameter int ROW_LEN  = 3,
  parameter int NUM_PASS = 3
) (
  input logic                                     clk_i,
  input logic                                     rst_n,
  input logic                                     start_acc,
  input logic                                     wr_en,
  input logic                                     b_en,
  input logic                                     done_o,
  input logic [NUM_PASS*NUM_CH*ROW_LEN*DATA_W-1:0] weights_o,
  input logic [NUM_CH*DATA_W-1:0]                  bias_o
);

  localparam int TOTAL = NUM_PASS * NUM_CH + NUM_CH + 1;
  localparam int CNT_W = $clog2(TOTAL + 2);

  logic [CNT_W-1:0] cyc_q;

  // Edges since the start strobe was accepted (0 when no load runs)
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q <= '0;
    end else if (start_acc) begin
      cyc_q <= CNT_W'(1);
    end else if (done_o) begin
      cyc_q <= '0;
    end else if (cyc_q != '0) begin
      cyc_q <= cyc_q + 1'b1;
    end
  end

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_done_latency: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> (cyc_q == CNT_W'(TOTAL)));

  a_r7_no_restart: assert property (@(posedge clk_i) disable iff (!rst_n)
    start_acc |-> (cyc_q == '0));

  a_r8_weights_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    !wr_en |=> $stable(weights_o));

  a_r5_bias_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    !b_en |=> $stable(bias_o));

endmodule

bind kwl_loader kwl_loader_chk #(
  .DATA_W  (DATA_W),
  .NUM_CH  (NUM_CH),
  .ROW_LEN (ROW_LEN),
  .NUM_PASS(NUM_PASS)
) u_chk (
  .clk_i    (clk_i),
  .rst_n    (rst_sync_n),
  .start_acc(start_acc),
  .wr_en    (stg_vld),
  .b_en     (bload),
  .done_o   (done_o),
  .weights_o(weights_o),
  .bias_o   (bias_o)
);

// File: tb/kwl_loader_tb.sv
module kwl_loader_tb;

  localparam int NW = 36;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         start_i;
  logic [23:0]  grp_i;
  logic [7:0]   bias_i;
  logic [287:0] weights_o;
  logic [31:0]  bias_o;
  logic         done_o;

  int vec = 0;
  int bad = 0;
  logic [7:0] exp_w [NW];
  logic [7:0] exp_b [4];

  always #2 clk_i = ~clk_i;

  kwl_loader u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .grp_i    (grp_i),
    .bias_i   (bias_i),
    .weights_o(weights_o),
    .bias_o   (bias_o),
    .done_o   (done_o)
  );

  function automatic logic [7:0] wv(int run, int g, int k);
    return 8'((run * 71 + g * 13 + k * 7 + 128) % 256);
  endfunction

  function automatic logic [7:0] bv(int run, int c);
    return 8'((run * 45 + c * 19 + 200) % 256);
  endfunction

  task automatic chk_w(string req);
    logic [287:0] e;
    for (int i = 0; i < NW; i++) e[i*8 +: 8] = exp_w[i];
    vec++;
    if (weights_o !== e) begin
      bad++;
      $display("FAIL %s weights_o actual %h expected %h", req, weights_o, e);
    end
  endtask

  task automatic chk_b(string req);
    logic [31:0] e;
    for (int c = 0; c < 4; c++) e[c*8 +: 8] = exp_b[c];
    vec++;
    if (bias_o !== e) begin
      bad++;
      $display("FAIL %s bias_o actual %h expected %h", req, bias_o, e);
    end
  endtask

  task automatic chk_d(string req, logic e);
    vec++;
    if (done_o !== e) begin
      bad++;
      $display("FAIL %s done_o actual %b expected %b", req, done_o, e);
    end
  endtask

  task automatic clear_exp();
    for (int i = 0; i < NW; i++) exp_w[i] = '0;
    for (int c = 0; c < 4; c++) exp_b[c] = '0;
  endtask

  // One load; entered and left at a falling edge.
  // poke: extra start strobes mid-load and during done (R7).
  // last_t: final edge index; abort_t: reset asserted before that edge (R1).
  task automatic run_load(int run, bit poke, int last_t, int abort_t);
    for (int t = 0; t <= last_t; t++) begin
      if (t == abort_t) begin
        rst_ni = 1'b0;
        #1;
        clear_exp();
        chk_w("R1 abort");
        chk_b("R1 abort");
        chk_d("R1 abort", 1'b0);
        @(negedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        start_i = 1'b0;
        for (int j = 0; j < 3; j++) @(negedge clk_i);
        return;
      end
      start_i = (t == 0) || (poke && (t == 5 || t == 17));
      for (int k = 0; k < 3; k++) grp_i[k*8 +: 8] = 8'((t * 97 + run * 31 + k * 3 + 5) % 256);
      bias_i = 8'((t * 59 + run * 17 + 9) % 256);
      if (t >= 1 && t <= 12)
        for (int k = 0; k < 3; k++) grp_i[k*8 +: 8] = wv(run, t - 1, k);
      if (t >= 13 && t <= 16) bias_i = bv(run, 3 - (t - 13));
      @(posedge clk_i);
      @(negedge clk_i);
      if (t >= 2 && t <= 13) begin
        int g;
        int base;
        g = t - 2;
        base = ((g / 4) * 4 + (3 - g % 4)) * 3;
        for (int k = 0; k < 3; k++) exp_w[base + k] = wv(run, g, k);
      end
      if (t >= 13 && t <= 16) exp_b[3 - (t - 13)] = bv(run, 3 - (t - 13));
      if (t >= 18)      chk_w("R8 idle");
      else if (t == 13) chk_w("R4 last group with first bias");
      else              chk_w("R3/R4 placement");
      if (t <= 12)      chk_b("R8 bias ignored in weight phase");
      else              chk_b("R5 bias order");
      chk_d((poke ? "R7 done timing" : "R6 done pulse"), (t == 16));
    end
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    rst_ni  = 1'b0;
    start_i = 1'b0;
    grp_i   = '0;
    bias_i  = '0;
    clear_exp();
    for (int j = 0; j < 3; j++) @(negedge clk_i);
    chk_w("R1 reset");
    chk_b("R1 reset");
    chk_d("R1 reset", 1'b0);
    rst_ni = 1'b1;
    for (int j = 0; j < 3; j++) @(negedge clk_i);
    // R2/R3: plain loads with idle tail
    run_load(0, 1'b0, 21, -1);
    run_load(1, 1'b1, 21, -1);
    // R9: start on the first idle cycle after done
    run_load(2, 1'b0, 17, -1);
    run_load(3, 1'b1, 17, -1);
    run_load(4, 1'b0, 21, -1);
    // R1: reset in the middle of a load
    run_load(5, 1'b0, 21, 8);
    run_load(6, 1'b1, 21, -1);
    run_load(7, 1'b0, 23, -1);
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

endmodule